// File: doc/BRIEF.md
# Function-partitioned single-dword memory target

This block is the application end of a PCIe endpoint that supports I/O virtualization. It takes memory request TLPs that the transaction layer has received, works out which function each one targets, and reads or writes one dword of on-chip storage. Each function has its own region of that storage. There are two physical functions, and each one owns 32 virtual functions.

A request arrives as one valid/ready beat. The beat carries four things:
- the 3DW header,
- one dword of payload,
- the physical function number of the target,
- a flag saying a virtual function is addressed, together with that virtual function's number.

A memory write stores its payload and sends nothing back. A memory read returns one completion-with-data TLP on a valid/ready output. The target handles one request at a time. It takes nothing new until the current request has finished, and for a read that includes the handshake of its completion.

Top module: `fnmem_target`

## Requirements
- R1: The reset `rst` is synchronous and active-high. After a rising clock edge with `rst` high, `tx_valid` is 0 and `rx_ready` is 1, and a completion that was waiting is discarded. Reset does not clear the stored data.
- R2: The function number is PF when `rx_vf_act` is 0. When `rx_vf_act` is 1 it is 2 + PF*32 + VF. This gives 66 functions, numbered 0 to 65. Each function owns a separate region of 16 dwords, so the same address in two different functions never reaches the same dword.
- R3: A request is a memory write when header bits [95:93] are 3'b010, bits [92:88] are 5'b00000 and the length field [73:64] is 1. A memory write stores `rx_data` at dword offset addr[5:2] of its function's region, where addr is header bits [31:0], and produces no completion.
- R4: A request is a memory read when bits [95:93] are 3'b000, bits [92:88] are 5'b00000 and the length is 1. A memory read produces exactly one completion. The completion's `tx_data` is the dword currently stored at that offset in that function's region.
- R5: The completion header is built as follows:
  - Bits [95:64] are 32'h4A000001, which encodes a 3DW header with data, the completion type and a length of 1.
  - Bits [63:48] are the completer ID {BUS_NUM, function number}.
  - Bits [47:32] are 16'h0004, which encodes successful status and a byte count of 4.
  - Bits [31:16] copy the requester ID from request bits [63:48], and bits [15:8] copy the tag from request bits [47:40].
  - Bit 7 is 0, and bits [6:0] are {addr[6:2], 2'b00}.
- R6: Address bits [1:0] are ignored. They do not change the dword that is accessed, and they do not appear in the completion.
- R7: Any other request is dropped. This covers any other format or type, and a length other than 1. A dropped request sends no completion and leaves the storage unchanged.
- R8: Only one request is in progress at a time:
  - `rx_ready` is 0 in the cycle after every accepted request.
  - `rx_ready` stays 0 for as long as `tx_valid` is 1.
  - While `tx_valid` is 1 and `tx_ready` is 0, the completion holds steady.
- R9: If every function writes a value and every function then reads it back, each function returns its own value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Request beat valid |
| rx_ready | output | 1 | Target can take a request |
| rx_hdr | input | 96 | Request header, DW0 in [95:64], DW1 in [63:32], DW2 in [31:0] |
| rx_data | input | 32 | Write payload dword |
| rx_pf | input | 1 | Physical function number of the request |
| rx_vf_act | input | 1 | Request targets a virtual function |
| rx_vf_num | input | 5 | Virtual function number within its physical function |
| tx_valid | output | 1 | Completion valid |
| tx_ready | input | 1 | Downstream accepts the completion |
| tx_hdr | output | 96 | Completion header, same dword layout as the request |
| tx_data | output | 32 | Completion payload dword |

## Verification
The bench builds the target with its default parameters:
- 2 physical functions,
- 32 virtual functions per physical function,
- 16-dword regions,
- bus number 3.

These values make all 66 regions reachable. They also bring within reach the first virtual-function region (number 2), the boundary between the two physical functions' virtual-function ranges (33 and 34), and the last region (65). Because every function uses the same dword offset, aliasing anywhere in the index arithmetic would show up. With 16-dword regions, offset 15 and the address bits above bit 5 can also be tested for whether they are truly ignored. Random stalls on `tx_ready`, and a reset while a completion is waiting, exercise the single-outstanding rule.

// File: rtl/fnmem_pkg.sv
package fnmem_pkg;

    localparam logic [2:0] FMT_3DW_NODATA = 3'b000;
    localparam logic [2:0] FMT_3DW_DATA   = 3'b010;
    localparam logic [4:0] TYPE_MEM       = 5'b00000;
    localparam logic [4:0] TYPE_CPL       = 5'b01010;
    localparam logic [2:0] CPL_STATUS_SC  = 3'b000;
    localparam logic [11:0] CPL_BYTES     = 12'd4;

    typedef enum logic [1:0] {
        RQ_DROP  = 2'd0,
        RQ_WRITE = 2'd1,
        RQ_READ  = 2'd2
    } rq_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_CPL  = 2'd2
    } state_e;

    typedef struct packed {
        rq_kind_e    kind;
        logic [7:0]  fnum;
        logic [7:0]  offset;
        logic [6:0]  low_addr;
        logic [15:0] req_id;
        logic [7:0]  tag;
        logic [31:0] data;
    } req_t;

    function automatic logic [7:0] func_number(input logic [7:0] pf,
                                               input logic       vf_act,
                                               input logic [7:0] vf,
                                               input int         num_pf,
                                               input int         vf_per_pf);
        int n;
        if (vf_act)
            n = num_pf + int'(pf) * vf_per_pf + int'(vf);
        else
            n = int'(pf);
        return n[7:0];
    endfunction

    function automatic logic [95:0] cpl_header(input logic [15:0] cid,
                                               input req_t        r);
        return {FMT_3DW_DATA, TYPE_CPL, 14'b0, 10'd1,
                cid, CPL_STATUS_SC, 1'b0, CPL_BYTES,
                r.req_id, r.tag, 1'b0, r.low_addr};
    endfunction

endpackage

// File: rtl/fnmem_req_decode.sv
module fnmem_req_decode
    import fnmem_pkg::*;
#(
    parameter int NUM_PF    = 2,
    parameter int VF_PER_PF = 32,
    parameter int PF_W      = 1,
    parameter int VF_W      = 5,
    parameter int OFF_W     = 4
) (
    input  logic [95:0]     hdr,
    input  logic [31:0]     data,
    input  logic [PF_W-1:0] pf,
    input  logic            vf_act,
    input  logic [VF_W-1:0] vf,
    output req_t            req
);

    logic [2:0]  fmt;
    logic [4:0]  typ;
    logic [9:0]  len;
    logic [31:0] addr;
    logic        unused_fields;

    assign fmt  = hdr[95:93];
    assign typ  = hdr[92:88];
    assign len  = hdr[73:64];
    assign addr = hdr[31:0];
    assign unused_fields = ^{hdr[87:74], hdr[39:32], addr[31:7], addr[1:0]};

    always_comb begin
        req.kind = RQ_DROP;
        if (typ == TYPE_MEM && len == 10'd1) begin
            if (fmt == FMT_3DW_DATA)
                req.kind = RQ_WRITE;
            else if (fmt == FMT_3DW_NODATA)
                req.kind = RQ_READ;
        end
        req.fnum     = func_number(8'(pf), vf_act, 8'(vf), NUM_PF, VF_PER_PF);
        req.offset   = 8'(addr[OFF_W+1:2]);
        req.low_addr = {addr[6:2], 2'b00};
        req.req_id   = hdr[63:48];
        req.tag      = hdr[47:40];
        req.data     = data;
    end

endmodule

// File: rtl/fnmem_store.sv
module fnmem_store #(
    parameter int NFUNC  = 66,
    parameter int OFF_W  = 4,
    parameter int DEPTH  = NFUNC << OFF_W,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [7:0]       fnum,
    input  logic [OFF_W-1:0] offset,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata
);

    logic [31:0]       mem [DEPTH];
    logic [ADDR_W-1:0] idx;

    assign idx   = ADDR_W'({fnum, offset});
    assign rdata = mem[idx];

    always_ff @(posedge clk) begin
        if (we)
            mem[idx] <= wdata;
    end

endmodule

// File: rtl/fnmem_cpl_build.sv
module fnmem_cpl_build
    import fnmem_pkg::*;
#(
    parameter logic [7:0] BUS_NUM = 8'h03
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  req_t        req,
    input  logic [31:0] rdata,
    input  logic        tx_ready,
    output logic        tx_valid,
    output logic [95:0] tx_hdr,
    output logic [31:0] tx_data
);

    logic unused_req;
    assign unused_req = ^{req.kind, req.offset, req.data};

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid <= 1'b0;
        end else if (load) begin
            tx_valid <= 1'b1;
        end else if (tx_valid && tx_ready) begin
            tx_valid <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (load) begin
            tx_hdr  <= cpl_header({BUS_NUM, req.fnum}, req);
            tx_data <= rdata;
        end
    end

endmodule

// File: rtl/fnmem_target.sv
module fnmem_target
    import fnmem_pkg::*;
#(
    parameter int         NUM_PF    = 2,
    parameter int         VF_PER_PF = 32,
    parameter int         REGION_DW = 16,
    parameter logic [7:0] BUS_NUM   = 8'h03,
    localparam int        PF_W      = $clog2(NUM_PF),
    localparam int        VF_W      = $clog2(VF_PER_PF),
    localparam int        OFF_W     = $clog2(REGION_DW),
    localparam int        NFUNC     = NUM_PF * (1 + VF_PER_PF)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rx_valid,
    output logic            rx_ready,
    input  logic [95:0]     rx_hdr,
    input  logic [31:0]     rx_data,
    input  logic [PF_W-1:0] rx_pf,
    input  logic            rx_vf_act,
    input  logic [VF_W-1:0] rx_vf_num,
    output logic            tx_valid,
    input  logic            tx_ready,
    output logic [95:0]     tx_hdr,
    output logic [31:0]     tx_data
);

    state_e      state;
    req_t        req_d;
    req_t        req_q;
    logic        accept;
    logic        mem_we;
    logic        cpl_load;
    logic [31:0] mem_rdata;

    assign rx_ready = (state == ST_IDLE);
    assign accept   = rx_valid && rx_ready;
    assign mem_we   = (state == ST_EXEC) && (req_q.kind == RQ_WRITE);
    assign cpl_load = (state == ST_EXEC) && (req_q.kind == RQ_READ);

    fnmem_req_decode #(
        .NUM_PF    (NUM_PF),
        .VF_PER_PF (VF_PER_PF),
        .PF_W      (PF_W),
        .VF_W      (VF_W),
        .OFF_W     (OFF_W)
    ) u_decode (
        .hdr    (rx_hdr),
        .data   (rx_data),
        .pf     (rx_pf),
        .vf_act (rx_vf_act),
        .vf     (rx_vf_num),
        .req    (req_d)
    );

    fnmem_store #(
        .NFUNC (NFUNC),
        .OFF_W (OFF_W)
    ) u_store (
        .clk    (clk),
        .we     (mem_we),
        .fnum   (req_q.fnum),
        .offset (req_q.offset[OFF_W-1:0]),
        .wdata  (req_q.data),
        .rdata  (mem_rdata)
    );

    fnmem_cpl_build #(
        .BUS_NUM (BUS_NUM)
    ) u_cpl (
        .clk      (clk),
        .rst      (rst),
        .load     (cpl_load),
        .req      (req_q),
        .rdata    (mem_rdata),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_hdr   (tx_hdr),
        .tx_data  (tx_data)
    );

    always_ff @(posedge clk) begin
        if (accept)
            req_q <= req_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (accept) state <= ST_EXEC;
                ST_EXEC: state <= (req_q.kind == RQ_READ) ? ST_CPL : ST_IDLE;
                ST_CPL:  if (tx_valid && tx_ready) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fnmem_target_chk.sv
module fnmem_target_chk (
    input logic        clk,
    input logic        rst,
    input logic        rx_valid,
    input logic        rx_ready,
    input logic [95:0] rx_hdr,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic [95:0] tx_hdr,
    input logic [31:0] tx_data
);

    logic acc;
    logic is_wr;
    logic is_rd;

    assign acc   = rx_valid && rx_ready;
    assign is_wr = rx_hdr[95:88] == 8'b010_00000 && rx_hdr[73:64] == 10'd1;
    assign is_rd = rx_hdr[95:88] == 8'b000_00000 && rx_hdr[73:64] == 10'd1;

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        acc |=> !rx_ready); // R8
    AST_CPL_BLOCKS_RX: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !rx_ready); // R8
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_hdr) && $stable(tx_data))); // R8
    AST_READ_GIVES_CPL: assert property (@(posedge clk) disable iff (rst)
        (acc && is_rd) |=> ##1 tx_valid); // R4
    AST_WRITE_NO_CPL: assert property (@(posedge clk) disable iff (rst)
        (acc && is_wr) |=> ##1 !tx_valid); // R3
    AST_DROP_NO_CPL: assert property (@(posedge clk) disable iff (rst)
        (acc && !is_rd && !is_wr) |=> ##1 !tx_valid); // R7
    AST_CPL_SHAPE: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> (tx_hdr[95:64] == 32'h4A000001 && tx_hdr[47:32] == 16'h0004
                      && !tx_hdr[7] && tx_hdr[1:0] == 2'b00)); // R5

endmodule

bind fnmem_target fnmem_target_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rx_hdr   (rx_hdr),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_hdr   (tx_hdr),
    .tx_data  (tx_data)
);

// File: tb/fnmem_target_bench.sv
module fnmem_target_bench;

    localparam int         NFUNC  = 66;
    localparam int         REGION = 16;
    localparam logic [7:0] BUS    = 8'h03;
    localparam logic [15:0] RID   = 16'h0100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [95:0] rx_hdr = '0;
    logic [31:0] rx_data = '0;
    logic [0:0]  rx_pf = '0;
    logic        rx_vf_act = 1'b0;
    logic [4:0]  rx_vf_num = '0;
    logic        tx_valid;
    logic        tx_ready = 1'b1;
    logic [95:0] tx_hdr;
    logic [31:0] tx_data;

    always #4 clk = ~clk;

    fnmem_target u_fnmem_target (
        .clk       (clk),
        .rst       (rst),
        .rx_valid  (rx_valid),
        .rx_ready  (rx_ready),
        .rx_hdr    (rx_hdr),
        .rx_data   (rx_data),
        .rx_pf     (rx_pf),
        .rx_vf_act (rx_vf_act),
        .rx_vf_num (rx_vf_num),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .tx_hdr    (tx_hdr),
        .tx_data   (tx_data)
    );

    int checks = 0;
    int errors = 0;
    int ready_mode = 0;
    bit finished = 1'b0;
    logic [127:0] expq[$];
    string        tagq[$];
    logic [31:0]  model [NFUNC*REGION];

    task automatic chk(input bit ok, input string rq,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (ready_mode == 0) tx_ready = 1'b1;
            else if (ready_mode == 1) tx_ready = ($urandom % 3) == 0;
            else tx_ready = 1'b0;
        end
    end

    logic        stall_seen = 1'b0;
    logic [127:0] stall_val;
    always @(negedge clk) begin
        if (!rst) begin
            if (stall_seen)
                chk(tx_valid && {tx_hdr, tx_data} == stall_val, "R8 hold",
                    {tx_hdr, tx_data}, stall_val);
            if (tx_valid && tx_ready) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R7 unexpected completion", {tx_hdr, tx_data}, '0);
                end else begin
                    logic [127:0] e;
                    string t;
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    chk(tx_hdr == e[127:32], "R5 header", {32'h0, tx_hdr}, {32'h0, e[127:32]});
                    chk(tx_data == e[31:0], t, {96'h0, tx_data}, {96'h0, e[31:0]});
                end
            end
            if (tx_valid)
                chk(!rx_ready, "R8 ready low", {127'h0, rx_ready}, '0);
        end
        stall_seen = !rst && tx_valid && !tx_ready;
        stall_val  = {tx_hdr, tx_data};
    end

    task automatic send(input int f, input logic [2:0] fmt, input logic [4:0] typ,
                        input logic [9:0] len, input logic [31:0] addr,
                        input logic [31:0] data, input logic [7:0] tag,
                        input string rq);
        int g;
        @(negedge clk);
        while (!rx_ready) @(negedge clk);
        if (f < 2) begin
            rx_pf = f[0:0]; rx_vf_act = 1'b0; rx_vf_num = '0;
        end else begin
            g = f - 2;
            rx_pf = 1'((g / 32)); rx_vf_act = 1'b1; rx_vf_num = 5'(g % 32);
        end
        rx_hdr   = {fmt, typ, 14'h0, len, RID, tag, 8'h0F, addr};
        rx_data  = data;
        rx_valid = 1'b1;
        if (typ == 5'd0 && len == 10'd1) begin
            if (fmt == 3'b010) begin
                model[f*REGION + int'(addr[5:2])] = data;
            end else if (fmt == 3'b000) begin
                expq.push_back({32'h4A000001, BUS, 8'(f), 16'h0004,
                                RID, tag, 1'b0, addr[6:2], 2'b00,
                                model[f*REGION + int'(addr[5:2])]});
                tagq.push_back(rq);
            end
        end
        @(negedge clk);
        rx_valid = 1'b0;
        chk(!rx_ready, "R8 after accept", {127'h0, rx_ready}, '0);
    endtask

    task automatic wr(input int f, input logic [31:0] a, input logic [31:0] d);
        send(f, 3'b010, 5'd0, 10'd1, a, d, 8'h00, "R3");
    endtask

    task automatic rd(input int f, input logic [31:0] a, input logic [7:0] tag,
                      input string rq);
        send(f, 3'b000, 5'd0, 10'd1, a, 32'h0, tag, rq);
    endtask

    task automatic drain();
        int n = 0;
        while ((expq.size() != 0 || !rx_ready) && n < 2000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
        chk(expq.size() == 0, "R4 drained", 128'(expq.size()), '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(rx_ready == 1'b1, "R1 ready", {127'h0, rx_ready}, 128'h1);
        chk(tx_valid == 1'b0, "R1 valid", {127'h0, tx_valid}, '0);

        for (int f = 0; f < NFUNC; f++)
            wr(f, 32'h0000_000C, 32'hA500_0000 ^ 32'(f * 32'h0101));
        for (int f = 0; f < NFUNC; f++)
            rd(f, 32'h0000_000C, 8'(f), "R2");
        drain();

        for (int f = 0; f < NFUNC; f++) begin
            wr(f, 32'(f % REGION) << 2, 32'h1234_0000 + 32'(f));
            rd(f, 32'(f % REGION) << 2, 8'(f + 8'h80), "R9");
        end
        drain();

        wr(34, 32'h0000_003F, 32'hCAFE_0003);
        rd(34, 32'h0000_003D, 8'h11, "R6");
        rd(65, 32'hFFFF_FFFE, 8'h12, "R6");
        drain();

        send(5, 3'b010, 5'd0, 10'd2, 32'h0000_000C, 32'hDEAD_0001, 8'h0, "R7");
        send(5, 3'b010, 5'b00100, 10'd1, 32'h0000_000C, 32'hDEAD_0002, 8'h0, "R7");
        send(5, 3'b011, 5'd0, 10'd1, 32'h0000_000C, 32'hDEAD_0003, 8'h0, "R7");
        send(5, 3'b000, 5'd0, 10'd2, 32'h0000_000C, 32'h0, 8'h21, "R7");
        send(5, 3'b000, 5'b00001, 10'd1, 32'h0000_000C, 32'h0, 8'h22, "R7");
        rd(5, 32'h0000_000C, 8'h23, "R7");
        drain();

        ready_mode = 1;
        for (int f = 30; f < 40; f++)
            rd(f, 32'h0000_000C, 8'(f), "R8");
        drain();
        ready_mode = 0;

        ready_mode = 2;
        rd(7, 32'h0000_000C, 8'h44, "R1");
        repeat (3) @(negedge clk);
        chk(tx_valid == 1'b1, "R8 pending", {127'h0, tx_valid}, 128'h1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        void'(expq.pop_front());
        void'(tagq.pop_front());
        chk(tx_valid == 1'b0, "R1 valid cleared", {127'h0, tx_valid}, '0);
        chk(rx_ready == 1'b1, "R1 ready restored", {127'h0, rx_ready}, 128'h1);
        ready_mode = 0;
        rd(7, 32'h0000_000C, 8'h45, "R1");
        rd(2, 32'h0000_0008, 8'h46, "R1");
        drain();

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule